// File: doc/BRIEF.md
# Asynchronous fault status logger

This block collects error reports from a memory subsystem into one status word that software can read and clear. Each cycle the error sources may raise any set of one-cycle type pulses. All pulses in a cycle share a physical address, a data ECC syndrome, a tag ECC syndrome, the privilege level of the processor, a bus transaction id and a 16-byte subunit index. Every error type owns a sticky status bit. A multiple-error flag records repeats of the more serious ECC classes, and a privilege bit records the mode in force at the most recent logged error.

One fault address register and the two syndrome fields are shared by all error types. They are locked to the highest-priority event logged so far. A higher-priority event replaces the captured values. The lock is released only when software clears the status bit of the captured type, even if other status bits are still set. Inside one bus transaction, only ECC errors from the subunit that first reported one are logged.

Software reads `rdData` at any time and has no side effect by reading. It clears bits by writing ones through `wrEn`/`wrData`. `irq` stays high while any error bit is set.

Top module: `fault_status_log`

## Requirements
- R1: Error type i (0..18) owns status bit 33+i of `rdData`. The bit sets on a logged pulse of that type and stays set until a write with 1 in that position. Reading has no effect on it.
- R2: The data syndrome sits at `rdData[8:0]` and the tag syndrome at `rdData[19:16]`. Both are read-only, so writes to those positions change nothing. All bits of `rdData` not named in R1 to R5 read as 0.
- R3: Bit 53 (multiple error) sets when a software-correctable (type 5) or uncorrectable (types 6..11) event is logged while its own status bit is already set. Repeats of hardware-corrected types (0..4) or bus/protocol types (12..18) leave it unchanged. Writing 1 to bit 53 clears it.
- R4: ECC types are 0..11. A pulse of an ECC type is discarded when its transaction id equals that of the last logged ECC event and its subunit index differs. A new transaction id is logged. Bus/protocol types are never discarded.
- R5: Bit 52 takes the privilege input of each cycle in which at least one event is logged. Writing 1 to bit 52 clears it.
- R6: Priority equals type index. The captured address and syndromes are replaced only by an event of strictly higher index than the captured one. Among same-cycle pulses, the highest index is the one captured.
- R7: Clearing the status bit of the captured type releases the lock, even if other bits stay set. The next logged event of any priority is then captured.
- R8: The captured address and syndromes keep their values across release until a new capture. A repeat of the captured type keeps the first occurrence.
- R9: `irq` is high exactly while any status bit 51:33 is set.
- R10: A synchronous active-high `rst` clears all status, flags, the address, both syndromes, the lock and the transaction filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evtValid | input | 19 | One-cycle error pulse per type |
| evtAddr | input | ADDR_W | Physical address of the event |
| evtDataSyn | input | 9 | Data ECC syndrome |
| evtTagSyn | input | 4 | Tag ECC syndrome |
| evtPriv | input | 1 | Privilege level at detection |
| evtTxn | input | TXN_W | Bus transaction id |
| evtSub | input | SUB_W | 16-byte subunit index within the transaction |
| wrEn | input | 1 | Write strobe for write-one-to-clear |
| wrData | input | 64 | Write data; ones clear the bits they hit |
| rdData | output | 64 | Status word |
| faultAddr | output | ADDR_W | Captured fault address |
| irq | output | 1 | High while any error status bit is set |

## Verification
The captured-type lock is internal, and an error in it shows only at `faultAddr` and the syndrome fields. Such an error appears in the first cycle after the next event, when a higher or lower type overwrites, or fails to overwrite, the captured values. The directed tests therefore follow each event or clear with a compare of the whole status word and the address, taken one clock after the stimulus. A broken transaction filter shows as a status bit that sets when it should not, or stays clear when it should set, one cycle after the pulse.

// File: rtl/fault_log_pkg.sv
package fault_log_pkg;
  localparam int NUM_TYPES = 19;
  localparam int NUM_HC    = 5;   // hardware-corrected types 0..4
  localparam int NUM_SC    = 1;   // software-correctable type 5
  localparam int NUM_UC    = 6;   // uncorrectable types 6..11
  localparam int NUM_ECC   = NUM_HC + NUM_SC + NUM_UC;
  localparam int REG_W     = 64;
  localparam int STAT_LSB  = 33;
  localparam int PRIV_BIT  = 52;
  localparam int MULTI_BIT = 53;
  localparam int DSYN_W    = 9;
  localparam int TSYN_W    = 4;
  localparam int TSYN_LSB  = 16;
  localparam int IDX_W     = $clog2(NUM_TYPES);

  typedef logic [NUM_TYPES-1:0] typeVec_t;

  typedef struct packed {
    typeVec_t setMask;
    typeVec_t clrMask;
    logic     multiSet;
    logic     multiClr;
    logic     privLoad;
    logic     privClr;
    logic     captureEn;
  } strobe_t;

  function automatic typeVec_t spanMask(int lo, int hi);
    typeVec_t m;
    m = '0;
    for (int i = 0; i < NUM_TYPES; i++) begin
      if (i >= lo && i <= hi) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/fault_status_ctrl.sv
module fault_status_ctrl
  import fault_log_pkg::*;
#(
  parameter int TXN_W = 4,
  parameter int SUB_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  typeVec_t             evtValid,
  input  logic [TXN_W-1:0]     evtTxn,
  input  logic [SUB_W-1:0]     evtSub,
  input  logic                 wrEn,
  input  logic [REG_W-1:0]     wrData,
  input  typeVec_t             statusIn,
  output strobe_t              strb
);
  localparam typeVec_t ECC_MASK   = spanMask(0, NUM_ECC - 1);
  localparam typeVec_t MULTI_MASK = spanMask(NUM_HC, NUM_ECC - 1);
  localparam logic [REG_W-1:0] USED_WR =
    ({{(REG_W-NUM_TYPES){1'b0}}, {NUM_TYPES{1'b1}}} << STAT_LSB)
    | (REG_W'(1) << PRIV_BIT) | (REG_W'(1) << MULTI_BIT);

  logic             eccSeen;
  logic [TXN_W-1:0] lastTxn;
  logic [SUB_W-1:0] lastSub;
  logic             heldValid;
  logic [IDX_W-1:0] heldIdx;

  logic             evtHasEcc, dropEcc, heldLive;
  typeVec_t         accMask, clrMask;
  logic [IDX_W-1:0] topIdx;
  logic             unusedWr;

  assign unusedWr  = ^(wrData & ~USED_WR);
  assign clrMask   = wrEn ? wrData[STAT_LSB +: NUM_TYPES] : '0;
  assign evtHasEcc = |(evtValid & ECC_MASK);
  assign dropEcc   = evtHasEcc && eccSeen && (evtTxn == lastTxn) && (evtSub != lastSub);
  assign accMask   = dropEcc ? (evtValid & ~ECC_MASK) : evtValid;
  assign heldLive  = heldValid && !clrMask[heldIdx];

  always_comb begin
    topIdx = '0;
    for (int i = 0; i < NUM_TYPES; i++) begin
      if (accMask[i]) topIdx = IDX_W'(i);
    end
  end

  always_comb begin
    strb.setMask   = accMask;
    strb.clrMask   = clrMask;
    strb.multiSet  = |(accMask & statusIn & MULTI_MASK);
    strb.multiClr  = wrEn && wrData[MULTI_BIT];
    strb.privLoad  = |accMask;
    strb.privClr   = wrEn && wrData[PRIV_BIT];
    strb.captureEn = (|accMask) && (!heldLive || (topIdx > heldIdx));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eccSeen   <= 1'b0;
      lastTxn   <= '0;
      lastSub   <= '0;
      heldValid <= 1'b0;
      heldIdx   <= '0;
    end else begin
      if (evtHasEcc && !dropEcc) begin
        eccSeen <= 1'b1;
        lastTxn <= evtTxn;
        lastSub <= evtSub;
      end
      if (strb.captureEn) begin
        heldValid <= 1'b1;
        heldIdx   <= topIdx;
      end else begin
        heldValid <= heldLive;
      end
    end
  end

  AST_HELD_IS_SET: assert property (@(posedge clk) disable iff (rst)
    heldValid |-> statusIn[heldIdx]); // R7
endmodule

// File: rtl/fault_status_dp.sv
module fault_status_dp
  import fault_log_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] evtAddr,
  input  logic [DSYN_W-1:0] evtDataSyn,
  input  logic [TSYN_W-1:0] evtTagSyn,
  input  logic              evtPriv,
  output typeVec_t          statusOut,
  output logic [REG_W-1:0]  rdData,
  output logic [ADDR_W-1:0] faultAddr,
  output logic              irq
);
  typeVec_t          status;
  logic              multiFlag, privFlag;
  logic [ADDR_W-1:0] addrReg;
  logic [DSYN_W-1:0] dataSyn;
  logic [TSYN_W-1:0] tagSyn;

  always_ff @(posedge clk) begin
    if (rst) begin
      status    <= '0;
      multiFlag <= 1'b0;
      privFlag  <= 1'b0;
      addrReg   <= '0;
      dataSyn   <= '0;
      tagSyn    <= '0;
    end else begin
      status <= (status & ~strb.clrMask) | strb.setMask;
      if (strb.multiSet)      multiFlag <= 1'b1;
      else if (strb.multiClr) multiFlag <= 1'b0;
      if (strb.privLoad)      privFlag <= evtPriv;
      else if (strb.privClr)  privFlag <= 1'b0;
      if (strb.captureEn) begin
        addrReg <= evtAddr;
        dataSyn <= evtDataSyn;
        tagSyn  <= evtTagSyn;
      end
    end
  end

  always_comb begin
    rdData = '0;
    rdData[STAT_LSB +: NUM_TYPES] = status;
    rdData[MULTI_BIT]             = multiFlag;
    rdData[PRIV_BIT]              = privFlag;
    rdData[TSYN_LSB +: TSYN_W]    = tagSyn;
    rdData[DSYN_W-1:0]            = dataSyn;
  end

  assign statusOut = status;
  assign faultAddr = addrReg;
  assign irq       = |status;

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((~status & $past(status) & ~$past(strb.clrMask)) == '0)); // R1
  AST_MULTI_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
    $rose(multiFlag) |-> $past(|strb.setMask)); // R3
  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rst && !strb.captureEn) |=> ($stable(addrReg) && $stable(dataSyn) && $stable(tagSyn))); // R8
endmodule

// File: rtl/fault_status_log.sv
module fault_status_log
  import fault_log_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int TXN_W  = 4,
  parameter int SUB_W  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_TYPES-1:0] evtValid,
  input  logic [ADDR_W-1:0]    evtAddr,
  input  logic [DSYN_W-1:0]    evtDataSyn,
  input  logic [TSYN_W-1:0]    evtTagSyn,
  input  logic                 evtPriv,
  input  logic [TXN_W-1:0]     evtTxn,
  input  logic [SUB_W-1:0]     evtSub,
  input  logic                 wrEn,
  input  logic [REG_W-1:0]     wrData,
  output logic [REG_W-1:0]     rdData,
  output logic [ADDR_W-1:0]    faultAddr,
  output logic                 irq
);
  strobe_t  strb;
  typeVec_t status;

  fault_status_ctrl #(.TXN_W(TXN_W), .SUB_W(SUB_W)) u_ctrl (
    .clk(clk), .rst(rst), .evtValid(evtValid), .evtTxn(evtTxn), .evtSub(evtSub),
    .wrEn(wrEn), .wrData(wrData), .statusIn(status), .strb(strb)
  );

  fault_status_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .evtAddr(evtAddr), .evtDataSyn(evtDataSyn),
    .evtTagSyn(evtTagSyn), .evtPriv(evtPriv), .statusOut(status), .rdData(rdData),
    .faultAddr(faultAddr), .irq(irq)
  );
endmodule

// File: tb/fault_status_log_tb.sv
module fault_status_log_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [18:0] evtValid = '0;
  logic [39:0] evtAddr = '0;
  logic [8:0]  evtDataSyn = '0;
  logic [3:0]  evtTagSyn = '0;
  logic        evtPriv = 1'b0;
  logic [3:0]  evtTxn = '0;
  logic [1:0]  evtSub = '0;
  logic        wrEn = 1'b0;
  logic [63:0] wrData = '0;
  logic [63:0] rdData;
  logic [39:0] faultAddr;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  fault_status_log u_dut (
    .clk(clk), .rst(rst), .evtValid(evtValid), .evtAddr(evtAddr), .evtDataSyn(evtDataSyn),
    .evtTagSyn(evtTagSyn), .evtPriv(evtPriv), .evtTxn(evtTxn), .evtSub(evtSub),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .faultAddr(faultAddr), .irq(irq)
  );

  function automatic logic [18:0] ty(int i);
    return 19'(1) << i;
  endfunction

  function automatic logic [63:0] word(logic [18:0] st, bit m, bit p, logic [3:0] t, logic [8:0] d);
    logic [63:0] w;
    w = '0;
    w[51:33] = st;
    w[53] = m;
    w[52] = p;
    w[19:16] = t;
    w[8:0] = d;
    return w;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic see(string req, logic [63:0] expWord, logic [39:0] expAddr);
    chk(req, rdData, expWord);
    chk(req, 64'(faultAddr), 64'(expAddr));
    chk(req, 64'(irq), 64'(|expWord[51:33]));
  endtask

  task automatic pulse(logic [18:0] v, logic [39:0] a, logic [8:0] d, logic [3:0] t,
                       bit p, logic [3:0] txn, logic [1:0] sub);
    @(negedge clk);
    evtValid = v; evtAddr = a; evtDataSyn = d; evtTagSyn = t;
    evtPriv = p; evtTxn = txn; evtSub = sub;
    @(negedge clk);
    evtValid = '0;
  endtask

  task automatic clear(logic [63:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic testReset();
    see("R10 reset state", 64'd0, 40'd0);
  endtask

  task automatic testFirstAndRepeatHc();
    pulse(ty(1), 40'h11, 9'h011, 4'h3, 1'b1, 4'd1, 2'd0);
    see("R1 R5 R9 first event", word(ty(1), 0, 1, 4'h3, 9'h011), 40'h11);
    pulse(ty(1), 40'h44, 9'h0AA, 4'hC, 1'b1, 4'd2, 2'd0);
    see("R3 R8 hc repeat no multi, first kept", word(ty(1), 0, 1, 4'h3, 9'h011), 40'h11);
  endtask

  task automatic testUcOverwriteAndMulti();
    pulse(ty(7), 40'h22, 9'h155, 4'h9, 1'b0, 4'd3, 2'd0);
    see("R6 uc overwrites hc", word(ty(1)|ty(7), 0, 0, 4'h9, 9'h155), 40'h22);
    pulse(ty(7), 40'h55, 9'h0F0, 4'h1, 1'b1, 4'd3, 2'd0);
    see("R3 uc repeat sets multi", word(ty(1)|ty(7), 1, 1, 4'h9, 9'h155), 40'h22);
  endtask

  task automatic testSubunitFilter();
    pulse(ty(2), 40'h66, 9'h033, 4'h2, 1'b0, 4'd3, 2'd2);
    see("R4 later subunit dropped", word(ty(1)|ty(7), 1, 1, 4'h9, 9'h155), 40'h22);
    pulse(ty(2), 40'h66, 9'h033, 4'h2, 1'b0, 4'd4, 2'd1);
    see("R4 new txn logged", word(ty(1)|ty(2)|ty(7), 1, 0, 4'h9, 9'h155), 40'h22);
  endtask

  task automatic testReleaseRule();
    clear(64'(1) << 34);
    see("R1 R7 clear other bit keeps lock", word(ty(2)|ty(7), 1, 0, 4'h9, 9'h155), 40'h22);
    pulse(ty(0), 40'h77, 9'h044, 4'h4, 1'b0, 4'd5, 2'd0);
    see("R6 lower event no overwrite", word(ty(0)|ty(2)|ty(7), 1, 0, 4'h9, 9'h155), 40'h22);
    clear(64'(1) << 40);
    see("R8 release keeps contents", word(ty(0)|ty(2), 1, 0, 4'h9, 9'h155), 40'h22);
    pulse(ty(0), 40'h33, 9'h077, 4'h7, 1'b1, 4'd6, 2'd0);
    see("R7 low event captured after release", word(ty(0)|ty(2), 1, 1, 4'h7, 9'h077), 40'h33);
  endtask

  task automatic testReadOnlySyn();
    clear(64'h0000_0000_000F_01FF);
    see("R2 syndrome write ignored", word(ty(0)|ty(2), 1, 1, 4'h7, 9'h077), 40'h33);
  endtask

  task automatic testSameCycle();
    pulse(ty(15)|ty(12)|ty(5), 40'h88, 9'h1E1, 4'hE, 1'b0, 4'd6, 2'd3);
    see("R6 R4 same cycle highest, bus kept", word(ty(0)|ty(2)|ty(12)|ty(15), 1, 0, 4'hE, 9'h1E1), 40'h88);
    pulse(ty(12), 40'h99, 9'h010, 4'h0, 1'b0, 4'd7, 2'd0);
    see("R6 bus lower no overwrite", word(ty(0)|ty(2)|ty(12)|ty(15), 1, 0, 4'hE, 9'h1E1), 40'h88);
  endtask

  task automatic testClearAllAndSc();
    clear(64'hFFFF_FFFF_FFFF_FFFF);
    see("R1 R3 R5 R9 clear all", word('0, 0, 0, 4'hE, 9'h1E1), 40'h88);
    pulse(ty(5), 40'hAA, 9'h0C3, 4'h5, 1'b1, 4'd8, 2'd0);
    see("R7 sc captured after full clear", word(ty(5), 0, 1, 4'h5, 9'h0C3), 40'hAA);
    pulse(ty(5), 40'hBB, 9'h03C, 4'h6, 1'b1, 4'd8, 2'd0);
    see("R3 sc repeat sets multi", word(ty(5), 1, 1, 4'h5, 9'h0C3), 40'hAA);
  endtask

  task automatic testMidReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    see("R10 reset clears all", 64'd0, 40'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testFirstAndRepeatHc();
    testUcOverwriteAndMulti();
    testSubunitFilter();
    testReleaseRule();
    testReadOnlySyn();
    testSameCycle();
    testClearAllAndSc();
    testMidReset();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule